// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block forms the byte a host sees when it reads a flash array while an embedded program or erase is running. It follows the life of one operation at a time: whether the controller is busy, whether the job is a byte program or a block erase, the top bit of the byte being written, a sticky failure flag and whether the erase-start window is still open. Each read strobe latches one status byte into a registered output. While nothing is running, the array byte supplied by the caller is latched instead, so the read path looks the same to the host in both cases.

The timing engine that runs the operation is outside the block. It reports the operation's end with a done pulse and any overrun or verify failure with a fail pulse. A program aimed at a protected target is dropped without trace. An erase whose selected blocks are all protected runs a short sham busy interval of a fixed number of clocks, and then the array read comes back.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `status_o` is 0x00 and `busy_o` is 0; `status_o` changes only on the clock edge that samples `rd_i` high and holds its value otherwise.
- R2: A read while idle latches `array_data_i` unchanged into `status_o`.
- R3: During a program operation, status bit 7 is the inverse of bit 7 of the byte being programmed.
- R4: During an erase operation, real or sham, status bit 7 is 0.
- R5: Status bit 6 starts at 0 on the first read after an operation is accepted and inverts on every following busy read.
- R6: While `susp_ack_i` is high, busy reads return the same bit 6 value, and that value does not advance.
- R7: Status bits 4, 2, 1 and 0 are 0 in every busy read.
- R8: Status bit 3 during an erase is the inverse of `window_open_i` (0 while the window is open, 1 after it closes); during a program it is 0.
- R9: A `fail_i` pulse while busy sets status bit 5 in every later busy read, across operations, until a `clr_err_i` pulse clears it.
- R10: A `done_i` pulse ends a real program or erase: `busy_o` falls on the next edge and reads pass array data again.
- R11: A program start with `protected_i` high is ignored: `busy_o` stays 0 and reads keep passing array data.
- R12: An erase start with `protected_i` high keeps `busy_o` high for exactly `FAKE_CYCLES` clocks, ignoring `done_i`, and then returns to array read.
- R13: A start pulse that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: an operation begins |
| start_erase_i | input | 1 | Kind of the starting operation: 1 erase, 0 program |
| protected_i | input | 1 | The target (program) or all selected blocks (erase) are protected |
| prog_data_i | input | 8 | Byte being programmed, sampled with `start_i` |
| done_i | input | 1 | One-cycle pulse from the timing engine: operation complete |
| fail_i | input | 1 | One-cycle pulse: operation overran or failed |
| clr_err_i | input | 1 | One-cycle pulse from a reset command: clear the failure flag |
| rd_i | input | 1 | Read strobe, one cycle per host read |
| window_open_i | input | 1 | Erase-start window still accepting further blocks |
| susp_ack_i | input | 1 | Erase suspend has been acknowledged |
| array_data_i | input | 8 | Array byte supplied by the caller for idle reads |
| status_o | output | 8 | Registered read result |
| busy_o | output | 1 | Operation in progress, sham interval included |

## Verification
A wrong toggle register shows as two equal bit 6 values on back-to-back busy reads, or as a 1 on the first read of an operation. Either shows up within the first two reads. A stale busy flag or a wrong sham counter shows as status bits where array data was expected, or the other way round, on the first read after the expected end. The bench checks `busy_o` on each clock of the sham interval. A lost or stuck failure flag shows on the next busy read after the fail or clear pulse. A wrong operation kind shows at once in bits 7 and 3.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int BYTE_W = 8;

  // bit positions inside the status byte; the host's polling code decodes these
  localparam int POLL_BIT   = 7;
  localparam int FLIP_BIT   = 6;
  localparam int FAULT_BIT  = 5;
  localparam int WINDOW_BIT = 3;

  typedef enum logic [1:0] {
    KIND_PROG  = 2'd0,
    KIND_ERASE = 2'd1,
    KIND_SHAM  = 2'd2
  } op_kind_t;
endpackage

// File: rtl/fsc_op_tracker.sv
module fsc_op_tracker
  import flash_status_pkg::*;
#(
  parameter int FAKE_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  logic     erase_i,
  input  logic     protected_i,
  input  logic     done_i,
  input  logic     prog_msb_i,
  output logic     busy_o,
  output op_kind_t kind_o,
  output logic     poll_bit_o,
  output logic     accept_o
);
  localparam int CW = $clog2(FAKE_CYCLES + 1);

  logic [CW-1:0] sham_cnt;

  // a protected program target is dropped; a protected erase runs a sham interval
  assign accept_o = start_i && !busy_o && (erase_i || !protected_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o     <= 1'b0;
      kind_o     <= KIND_PROG;
      poll_bit_o <= 1'b0;
      sham_cnt   <= '0;
    end else if (accept_o) begin
      busy_o     <= 1'b1;
      poll_bit_o <= ~prog_msb_i;
      sham_cnt   <= CW'(FAKE_CYCLES - 1);
      if (!erase_i)         kind_o <= KIND_PROG;
      else if (protected_i) kind_o <= KIND_SHAM;
      else                  kind_o <= KIND_ERASE;
    end else if (busy_o) begin
      if (kind_o == KIND_SHAM) begin
        if (sham_cnt == '0) busy_o <= 1'b0;
        else                sham_cnt <= sham_cnt - 1'b1;
      end else if (done_i) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsc_fault_flag.sv
module fsc_fault_flag (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic fail_i,
  input  logic clr_i,
  output logic fault_o
);
  // a failure report in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst)                  fault_o <= 1'b0;
    else if (fail_i && busy_i) fault_o <= 1'b1;
    else if (clr_i)           fault_o <= 1'b0;
  end
endmodule

// File: rtl/fsc_read_path.sv
module fsc_read_path
  import flash_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              busy_i,
  input  logic              restart_i,
  input  op_kind_t          kind_i,
  input  logic              poll_bit_i,
  input  logic              fault_i,
  input  logic              window_open_i,
  input  logic              susp_ack_i,
  input  logic [BYTE_W-1:0] array_data_i,
  output logic [BYTE_W-1:0] status_o
);
  logic              flip_q;
  logic [BYTE_W-1:0] busy_byte;

  always_comb begin
    busy_byte             = '0;
    busy_byte[FLIP_BIT]   = flip_q;
    busy_byte[FAULT_BIT]  = fault_i;
    if (kind_i == KIND_PROG) begin
      busy_byte[POLL_BIT]   = poll_bit_i;
      busy_byte[WINDOW_BIT] = 1'b0;
    end else begin
      busy_byte[POLL_BIT]   = 1'b0;
      busy_byte[WINDOW_BIT] = ~window_open_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flip_q   <= 1'b0;
      status_o <= '0;
    end else begin
      if (restart_i)
        flip_q <= 1'b0;
      else if (rd_i && busy_i && !susp_ack_i)
        flip_q <= ~flip_q;
      if (rd_i)
        status_o <= busy_i ? busy_byte : array_data_i;
    end
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int FAKE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       start_erase_i,
  input  logic       protected_i,
  input  logic [7:0] prog_data_i,
  input  logic       done_i,
  input  logic       fail_i,
  input  logic       clr_err_i,
  input  logic       rd_i,
  input  logic       window_open_i,
  input  logic       susp_ack_i,
  input  logic [7:0] array_data_i,
  output logic [7:0] status_o,
  output logic       busy_o
);
  op_kind_t kind;
  logic     poll_bit;
  logic     accept;
  logic     fault;

  fsc_op_tracker #(.FAKE_CYCLES(FAKE_CYCLES)) u_track (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .erase_i    (start_erase_i),
    .protected_i(protected_i),
    .done_i     (done_i),
    .prog_msb_i (prog_data_i[BYTE_W-1]),
    .busy_o     (busy_o),
    .kind_o     (kind),
    .poll_bit_o (poll_bit),
    .accept_o   (accept)
  );

  fsc_fault_flag u_fault (
    .clk    (clk),
    .rst    (rst),
    .busy_i (busy_o),
    .fail_i (fail_i),
    .clr_i  (clr_err_i),
    .fault_o(fault)
  );

  fsc_read_path u_read (
    .clk          (clk),
    .rst          (rst),
    .rd_i         (rd_i),
    .busy_i       (busy_o),
    .restart_i    (accept),
    .kind_i       (kind),
    .poll_bit_i   (poll_bit),
    .fault_i      (fault),
    .window_open_i(window_open_i),
    .susp_ack_i   (susp_ack_i),
    .array_data_i (array_data_i),
    .status_o     (status_o)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int FAKE_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       start_erase_i,
  input logic       protected_i,
  input logic       rd_i,
  input logic [7:0] status_o,
  input logic       busy_o
);
  localparam int LW = $clog2(FAKE_CYCLES + 2) + 1;

  logic          sham_run;
  logic [LW-1:0] sham_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sham_run <= 1'b0;
      sham_len <= '0;
    end else if (!busy_o && start_i && start_erase_i && protected_i) begin
      sham_run <= 1'b1;
      sham_len <= '0;
    end else if (sham_run) begin
      if (busy_o) sham_len <= sham_len + 1'b1;
      else        sham_run <= 1'b0;
    end
  end

  a_r1_hold_between_reads: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(status_o));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && busy_o) |=> (status_o[4] == 1'b0 && status_o[2:0] == 3'b000));

  a_r11_protected_program_dropped: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !start_erase_i && protected_i) |=> !busy_o);

  a_r12_sham_starts: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && start_erase_i && protected_i) |=> busy_o);

  a_r12_sham_bounded: assert property (@(posedge clk) disable iff (rst)
    sham_run |-> (sham_len <= LW'(FAKE_CYCLES)));

  a_r4_sham_poll_low: assert property (@(posedge clk) disable iff (rst)
    (sham_run && busy_o && rd_i) |=> !status_o[7]);
endmodule

bind flash_status_gen fsc_checker #(.FAKE_CYCLES(FAKE_CYCLES)) u_chk (.*);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int FAKE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 0, start_erase_i = 0, protected_i = 0;
  logic [7:0] prog_data_i = 0;
  logic       done_i = 0, fail_i = 0, clr_err_i = 0, rd_i = 0;
  logic       window_open_i = 0, susp_ack_i = 0;
  logic [7:0] array_data_i = 0;
  logic [7:0] status_o;
  logic       busy_o;

  int checks = 0;
  int errors = 0;
  logic exp_flip;
  logic exp_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.FAKE_CYCLES(FAKE)) uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start(input logic erase, input logic prot, input logic [7:0] d);
    start_i = 1; start_erase_i = erase; protected_i = prot; prog_data_i = d;
    @(negedge clk);
    start_i = 0; protected_i = 0;
    exp_flip = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1;
    @(negedge clk);
    sig = 0;
  endtask

  // one read strobe; result sampled at the following negedge
  task automatic do_read(input logic [7:0] arr, output logic [7:0] got);
    rd_i = 1; array_data_i = arr;
    @(negedge clk);
    rd_i = 0;
    got = status_o;
  endtask

  function automatic logic [7:0] busy_exp(input logic prog, input logic [7:0] d,
                                          input logic flip, input logic fault,
                                          input logic win_open);
    logic [7:0] b = 8'h00;
    b[7] = prog ? ~d[7] : 1'b0;
    b[6] = flip;
    b[5] = fault;
    b[3] = prog ? 1'b0 : ~win_open;
    return b;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] hold;
    exp_fault = 0;
    exp_flip = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset status", status_o, 8'h00);
    check("R1 reset busy", {7'b0, busy_o}, 8'h00);

    // R2: idle pass-through, several patterns
    for (int v = 0; v < 256; v += 17) begin
      do_read(8'(v), got);
      check("R2 idle read", got, 8'(v));
    end
    // R1: output holds without a read
    array_data_i = 8'hC3;
    @(negedge clk); @(negedge clk);
    check("R1 hold", status_o, 8'hFF);

    // R3 R5 R7 R8 R10: program sweep over every data byte
    for (int d = 0; d < 256; d++) begin
      pulse_start(1'b0, 1'b0, 8'(d));
      for (int r = 0; r < 3; r++) begin
        do_read(8'h00, got);
        check("R3 R5 R7 R8 program poll", got, busy_exp(1'b1, 8'(d), exp_flip, 1'b0, 1'b0));
        exp_flip = ~exp_flip;
      end
      pulse(done_i);
      check("R10 busy cleared", {7'b0, busy_o}, 8'h00);
      do_read(8'(d ^ 8'h5A), got);
      check("R10 array after done", got, 8'(d ^ 8'h5A));
    end

    // R4 R8: erase with window open then closed
    window_open_i = 1;
    pulse_start(1'b1, 1'b0, 8'hFF);
    do_read(8'hAA, got);
    check("R4 R8 erase window open", got, busy_exp(1'b0, 8'h00, exp_flip, 1'b0, 1'b1));
    exp_flip = ~exp_flip;
    window_open_i = 0;
    do_read(8'hAA, got);
    check("R4 R8 erase window closed", got, busy_exp(1'b0, 8'h00, exp_flip, 1'b0, 1'b0));
    exp_flip = ~exp_flip;

    // R13: start while busy ignored (program with msb 0 must not alter bit 7)
    pulse_start(1'b0, 1'b0, 8'h00);
    exp_flip = 1'b0; // erase continues: flip was reset by the bench task, restore model
    exp_flip = 1'b0;
    do_read(8'h11, got);
    check("R13 start while busy ignored", got, busy_exp(1'b0, 8'h00, 1'b0, 1'b0, 1'b0));
    exp_flip = 1'b1;

    // R6: suspend freezes bit 6
    susp_ack_i = 1;
    do_read(8'h00, got);
    hold = got;
    check("R6 suspend read a", got, busy_exp(1'b0, 8'h00, exp_flip, 1'b0, 1'b0));
    do_read(8'h00, got);
    check("R6 suspend read b", got, hold);
    susp_ack_i = 0;
    do_read(8'h00, got);
    check("R6 resume read", got, busy_exp(1'b0, 8'h00, exp_flip, 1'b0, 1'b0));
    exp_flip = ~exp_flip;

    // R9: fault sticky across operations until cleared
    pulse(fail_i);
    do_read(8'h00, got);
    check("R9 fault set", got, busy_exp(1'b0, 8'h00, exp_flip, 1'b1, 1'b0));
    pulse(done_i);
    do_read(8'h12, got);
    check("R9 idle passes array", got, 8'h12);
    pulse_start(1'b0, 1'b0, 8'h00);
    do_read(8'h00, got);
    check("R9 fault persists", got, busy_exp(1'b1, 8'h00, 1'b0, 1'b1, 1'b0));
    pulse(clr_err_i);
    do_read(8'h00, got);
    check("R9 fault cleared", got, busy_exp(1'b1, 8'h00, 1'b1, 1'b0, 1'b0));
    pulse(done_i);

    // R11: protected program ignored
    pulse_start(1'b0, 1'b1, 8'h00);
    check("R11 no busy", {7'b0, busy_o}, 8'h00);
    do_read(8'h3C, got);
    check("R11 array read", got, 8'h3C);

    // R12: sham erase lasts exactly FAKE clocks, done ignored
    pulse_start(1'b1, 1'b1, 8'h00);
    check("R12 sham busy start", {7'b0, busy_o}, 8'h01);
    for (int k = 1; k < FAKE; k++) begin
      if (k == 3) done_i = 1;
      @(negedge clk);
      done_i = 0;
    end
    check("R12 sham busy last", {7'b0, busy_o}, 8'h01);
    @(negedge clk);
    check("R12 sham ended", {7'b0, busy_o}, 8'h00);

    // R12 R4 R5: reads during a sham interval then array
    pulse_start(1'b1, 1'b1, 8'h00);
    do_read(8'hF0, got);
    check("R12 R4 sham read 0", got, busy_exp(1'b0, 8'h00, 1'b0, 1'b0, 1'b0));
    do_read(8'hF0, got);
    check("R12 R5 sham read 1", got, busy_exp(1'b0, 8'h00, 1'b1, 1'b0, 1'b0));
    for (int k = 0; k < FAKE; k++) @(negedge clk);
    do_read(8'hF0, got);
    check("R12 array after sham", got, 8'hF0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule